// File: doc/BRIEF.md
# Truncating Single-Precision Floating-Point Adder

This block adds or subtracts two single-precision (32-bit IEEE-754 layout) operands and is built to be small rather than exact. It has a fixed three-cycle pipeline and accepts a new operation every clock. Each operand is widened to a 28-bit working mantissa: two empty headroom bits, the implicit leading one, the 23 stored fraction bits, and two guard bits below the last stored place. The operand with the smaller exponent has its magnitude shifted right to line up with the other. Both magnitudes then take their signs and are summed in two's complement. The sum is turned back into sign and magnitude, renormalised with a leading-zero count, and packed with truncation.

Operands whose exponent field is zero count as zero. Results too small to be normal become zero, and results too large become infinity. Infinity and NaN are passed through so that they still mark a failed computation. A request is presented on `in_valid` with its operands. The matching result appears on `out_result`, with `out_valid` high, exactly three rising clock edges later.

Top module: `fp32_trunc_adder`

## Requirements
- R1: A request sampled with `in_valid` high on a rising edge gives `out_valid` high after the third rising edge that follows. A cycle with `in_valid` low gives `out_valid` low at the same distance. Back-to-back requests are accepted every cycle. While `rst_n` is low, `out_valid` is low.
- R2: For finite operands, each magnitude is formed as (1<<25) + (fraction<<2). The smaller-exponent magnitude is aligned, and the signed sum of both is taken. The result exponent is the larger input exponent plus p minus 25, where p is the bit position of the sum magnitude's leading one.
- R3: With `op_sub` high, the sign bit (bit 31) of `op_b` is inverted before the operation.
- R4: The magnitude of the operand with the smaller exponent field (bits 30:23) is shifted right by the exponent difference. Its sign is applied only after the shift, and bits shifted below the two guard positions are discarded. When the two exponent fields are equal, `op_a` is treated as the leading operand.
- R5: The 23 result fraction bits are the 23 bits directly below the leading one of the sum magnitude. Lower bits are dropped, with no rounding.
- R6: An operand whose exponent field is 0 is treated as zero, whatever its fraction bits are.
- R7: A nonzero sum whose result exponent would be 0 or below gives a zero with the sign of the sum. No output has a zero exponent field and a nonzero fraction.
- R8: A sum that is exactly zero gives 0x00000000.
- R9: A result exponent of 255 or more gives infinity (exponent field all ones, fraction 0) with the sign of the sum.
- R10: A NaN operand (exponent field 255, fraction nonzero) gives 0x7FC00000. So does adding two infinities of opposite effective sign. No other NaN encoding is ever produced.
- R11: An infinity combined with a finite operand, or with an infinity of the same effective sign, gives that infinity with its effective sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe for the operands on this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1: compute op_a - op_b, 0: op_a + op_b |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Truncated sum or difference |

## Verification
Every result, including specials and flushed zeros, is due on the third rising edge after the edge that samples its request. The valid strobe follows the same three-edge delay, even during idle gaps. The bench drives each request just after a falling edge and puts the value its model predicts into a queue that already holds three entries. At each later falling edge it removes one entry and compares it with the outputs. In this way every output is compared in exactly the cycle in which it is due, including idle cycles, where only `out_valid` is checked.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = EXP_W + FRAC_W + 1;
  localparam int MANT_W  = FRAC_W + 5;          // 2 headroom, hidden one, fraction, 2 guard
  localparam int IEXP_W  = EXP_W + 1;
  localparam int LZ_W    = $clog2(MANT_W + 1);
  localparam int ER_W    = IEXP_W + 2;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int HID_POS = MANT_W - 3;          // bit of the hidden one

  localparam logic [WORD_W-1:0] QNAN_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic              special;
    logic [WORD_W-1:0] spec_word;
    logic [IEXP_W-1:0] exp;
    logic [MANT_W-1:0] ma;   // two's complement
    logic [MANT_W-1:0] mb;   // two's complement
  } align_st_t;

  typedef struct packed {
    logic              special;
    logic [WORD_W-1:0] spec_word;
    logic [IEXP_W-1:0] exp;
    logic [MANT_W-1:0] sum;  // two's complement
  } sum_st_t;
endpackage

// File: rtl/fpa_lzc.sv
module fpa_lzc #(
  parameter int W   = 28,
  parameter int CNT = $clog2(W + 1)
) (
  input  logic [W-1:0]   vec,
  output logic [CNT-1:0] cnt
);
  always_comb begin
    cnt = CNT'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CNT'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpa_align.sv
module fpa_align
  import fpa_pkg::*;
(
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              op_sub,
  output align_st_t         st
);
  logic              sgn_a, sgn_b;
  logic [EXP_W-1:0]  ex_a, ex_b, dexp;
  logic [FRAC_W-1:0] fr_a, fr_b;
  logic [MANT_W-1:0] mag_a, mag_b, lead_mag, trail_mag, trail_sh;
  logic              lead_s, trail_s, a_leads;
  logic              nan_a, nan_b, inf_a, inf_b;

  always_comb begin
    sgn_a = op_a[WORD_W-1];
    sgn_b = op_b[WORD_W-1] ^ op_sub;
    ex_a  = op_a[WORD_W-2 -: EXP_W];
    ex_b  = op_b[WORD_W-2 -: EXP_W];
    fr_a  = op_a[FRAC_W-1:0];
    fr_b  = op_b[FRAC_W-1:0];

    mag_a = (ex_a == '0) ? '0 : {2'b00, 1'b1, fr_a, 2'b00};
    mag_b = (ex_b == '0) ? '0 : {2'b00, 1'b1, fr_b, 2'b00};

    a_leads   = (ex_a >= ex_b);
    dexp      = a_leads ? (ex_a - ex_b) : (ex_b - ex_a);
    lead_mag  = a_leads ? mag_a : mag_b;
    lead_s    = a_leads ? sgn_a : sgn_b;
    trail_mag = a_leads ? mag_b : mag_a;
    trail_s   = a_leads ? sgn_b : sgn_a;
    trail_sh  = trail_mag >> dexp;

    st.exp = {1'b0, (a_leads ? ex_a : ex_b)};
    st.ma  = lead_s  ? -lead_mag : lead_mag;
    st.mb  = trail_s ? -trail_sh : trail_sh;

    nan_a = (ex_a == EXP_W'(EXP_MAX)) && (fr_a != '0);
    nan_b = (ex_b == EXP_W'(EXP_MAX)) && (fr_b != '0);
    inf_a = (ex_a == EXP_W'(EXP_MAX)) && (fr_a == '0);
    inf_b = (ex_b == EXP_W'(EXP_MAX)) && (fr_b == '0);

    st.special = (ex_a == EXP_W'(EXP_MAX)) || (ex_b == EXP_W'(EXP_MAX));
    if (nan_a || nan_b || (inf_a && inf_b && (sgn_a != sgn_b)))
      st.spec_word = QNAN_WORD;
    else if (inf_a)
      st.spec_word = {sgn_a, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      st.spec_word = {sgn_b, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  end
endmodule

// File: rtl/fpa_pack.sv
module fpa_pack
  import fpa_pkg::*;
(
  input  sum_st_t           st,
  output logic [WORD_W-1:0] word
);
  logic              neg;
  logic [MANT_W-1:0] mag, unused_norm;
  logic [LZ_W-1:0]   lz;
  logic signed [ER_W-1:0] e_res;

  fpa_lzc #(.W(MANT_W), .CNT(LZ_W)) i_lzc (
    .vec (mag),
    .cnt (lz)
  );

  always_comb begin
    neg         = st.sum[MANT_W-1];
    mag         = neg ? -st.sum : st.sum;
    unused_norm = mag << lz;
    e_res = $signed({2'b00, st.exp}) + $signed(ER_W'(MANT_W - 1 - HID_POS))
          - $signed({{(ER_W-LZ_W){1'b0}}, lz});

    if (st.special)
      word = st.spec_word;
    else if (mag == '0)
      word = '0;
    else if (e_res <= $signed(ER_W'(0)))
      word = {neg, {(WORD_W-1){1'b0}}};
    else if (e_res >= $signed(ER_W'(EXP_MAX)))
      word = {neg, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      word = {neg, e_res[EXP_W-1:0], unused_norm[MANT_W-2 -: FRAC_W]};
  end
endmodule

// File: rtl/fp32_trunc_adder.sv
module fp32_trunc_adder
  import fpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              op_sub,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result
);
  align_st_t         s1_d, s1_q;
  sum_st_t           s2_d, s2_q;
  logic [WORD_W-1:0] s3_d;
  logic              s1_vld_q, s2_vld_q, s3_vld_q;
  logic [WORD_W-1:0] s3_q;

  // stage 1: unpack, order, align
  fpa_align i_align (
    .op_a   (op_a),
    .op_b   (op_b),
    .op_sub (op_sub),
    .st     (s1_d)
  );

  // stage 2: two's-complement sum
  always_comb begin
    s2_d.special   = s1_q.special;
    s2_d.spec_word = s1_q.spec_word;
    s2_d.exp       = s1_q.exp;
    s2_d.sum       = s1_q.ma + s1_q.mb;
  end

  // stage 3: renormalise and pack
  fpa_pack i_pack (
    .st   (s2_q),
    .word (s3_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
      s3_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= in_valid;
      s2_vld_q <= s1_vld_q;
      s3_vld_q <= s2_vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      if (in_valid) s1_q <= s1_d;
      if (s1_vld_q) s2_q <= s2_d;
      if (s2_vld_q) s3_q <= s3_d;
    end
  end

  assign out_valid  = s3_vld_q;
  assign out_result = s3_q;
endmodule

// File: rtl/fpa_checker.sv
module fpa_checker
  import fpa_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] op_a,
  input logic [WORD_W-1:0] op_b,
  input logic              op_sub,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_result
);
  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  a_r1_idle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);

  a_r10_canonical_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_result[WORD_W-2 -: EXP_W] == {EXP_W{1'b1}})
      |-> (out_result[FRAC_W-1:0] == '0 || out_result == QNAN_WORD));

  a_r7_no_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_result[WORD_W-2 -: EXP_W] == '0)
      |-> out_result[FRAC_W-1:0] == '0);

  a_r8_self_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_valid && op_sub && op_a == op_b
                        && op_a[WORD_W-2 -: EXP_W] != {EXP_W{1'b1}}, 3))
      |-> out_result == '0);

  a_r6_both_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_valid && op_a[WORD_W-2 -: EXP_W] == '0
                        && op_b[WORD_W-2 -: EXP_W] == '0, 3))
      |-> out_result == '0);
endmodule

bind fp32_trunc_adder fpa_checker i_chk (.*);

// File: tb/test_fp32_trunc_adder.sv
`timescale 1ns/1ps
module test_fp32_trunc_adder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, op_sub;
  logic [31:0] op_a, op_b;
  logic        out_valid;
  logic [31:0] out_result;

  always #2 clk = ~clk;   // 250 MHz

  fp32_trunc_adder i_fp32_trunc_adder (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .op_a (op_a), .op_b (op_b), .op_sub (op_sub),
    .out_valid (out_valid), .out_result (out_result)
  );

  int          n_checks = 0;
  int          n_fail   = 0;
  bit          q_v[$];
  logic [31:0] q_r[$];
  string       q_t[$];
  bit [31:0]   rng = 32'h1234_5678;

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, logic sub);
    int ea = int'(a[30:23]);
    int eb = int'(b[30:23]);
    bit sa = a[31];
    bit sb = b[31] ^ sub;
    bit nan_a = (ea == 255) && (a[22:0] != 0);
    bit nan_b = (eb == 255) && (b[22:0] != 0);
    longint ma, mb, sum, mag, frac;
    int emax, p, e;
    bit neg;
    if (nan_a || nan_b) return 32'h7FC0_0000;
    if (ea == 255 && eb == 255) return (sa == sb) ? {sa, 8'hFF, 23'd0} : 32'h7FC0_0000;
    if (ea == 255) return {sa, 8'hFF, 23'd0};
    if (eb == 255) return {sb, 8'hFF, 23'd0};
    ma = (ea == 0) ? 0 : (longint'(1) << 25) + (longint'(a[22:0]) << 2);
    mb = (eb == 0) ? 0 : (longint'(1) << 25) + (longint'(b[22:0]) << 2);
    if (ea >= eb) begin emax = ea; mb = mb >> (ea - eb); end
    else          begin emax = eb; ma = ma >> (eb - ea); end
    sum = (sa ? -ma : ma) + (sb ? -mb : mb);
    if (sum == 0) return 32'h0;
    neg = (sum < 0);
    mag = neg ? -sum : sum;
    p = 0;
    while ((mag >> (p + 1)) != 0) p++;
    e = emax + p - 25;
    if (e <= 0)   return {neg, 31'd0};
    if (e >= 255) return {neg, 8'hFF, 23'd0};
    frac = (p >= 23) ? (mag >> (p - 23)) : (mag << (23 - p));
    return {neg, e[7:0], frac[22:0]};
  endfunction

  task automatic compare();
    bit          ev = q_v.pop_front();
    logic [31:0] er = q_r.pop_front();
    string       tg = q_t.pop_front();
    n_checks++;
    if (out_valid !== ev) begin
      n_fail++;
      $display("FAIL %s out_valid actual=%b expected=%b", tg, out_valid, ev);
    end else if (ev && out_result !== er) begin
      n_fail++;
      $display("FAIL %s out_result actual=%h expected=%h", tg, out_result, er);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b,
                      input bit sub, input string tag);
    @(negedge clk);
    compare();
    in_valid = v; op_a = a; op_b = b; op_sub = sub;
    q_v.push_back(v);
    q_r.push_back(model(a, b, sub));
    q_t.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'h0, 32'h0, 1'b0, tag);
  endtask

  task automatic next_rand(output logic [31:0] r);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    r = rng;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb, rm;
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; op_sub = 1'b0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset out_valid actual=%b expected=0", out_valid);
    end
    rst_n = 1'b1;
    repeat (3) begin q_v.push_back(1'b0); q_r.push_back('0); q_t.push_back("R1"); end

    step(1, 32'h3F80_0000, 32'h3F80_0000, 0, "R2");   // 1 + 1 = 2
    step(1, 32'h3FC0_0000, 32'h4010_0000, 0, "R2");   // 1.5 + 2.25
    step(1, 32'hC0A0_0000, 32'h3F80_0000, 0, "R2");   // -5 + 1
    step(1, 32'h4040_0000, 32'h3F80_0000, 1, "R3");   // 3 - 1
    step(1, 32'h3F80_0000, 32'hC000_0000, 1, "R3");   // 1 - (-2)
    idle("R1");
    step(1, 32'h3F80_0000, 32'h3380_0000, 0, "R4");   // aligned into guard bits only
    step(1, 32'h3400_0000, 32'h3F80_0000, 0, "R4");   // smaller first, lands on ULP
    step(1, 32'h3F80_0000, 32'h0080_0000, 0, "R4");   // shifted out entirely
    step(1, 32'h3F80_0003, 32'h3F80_0000, 0, "R5");   // truncates instead of rounding up
    step(1, 32'h3F80_0000, 32'h3380_0000, 1, "R5");   // guard-only borrow
    step(1, 32'h0000_0001, 32'h3F80_0000, 0, "R6");   // subnormal counts as zero
    step(1, 32'h807F_FFFF, 32'h0040_0000, 0, "R6");   // two subnormals
    step(1, 32'h0080_0001, 32'h0080_0000, 1, "R7");   // underflow, positive
    step(1, 32'h0080_0000, 32'h0080_0001, 1, "R7");   // underflow, negative
    step(1, 32'h3F80_0000, 32'h3F80_0000, 1, "R8");   // exact cancel
    step(1, 32'hBF80_0000, 32'h3F80_0000, 0, "R8");   // -1 + 1
    step(1, 32'h8000_0000, 32'h8000_0000, 0, "R8");   // -0 + -0
    step(1, 32'h7F7F_FFFF, 32'h7F7F_FFFF, 0, "R9");   // overflow to +inf
    step(1, 32'hFF7F_FFFF, 32'h7F7F_FFFF, 1, "R9");   // overflow to -inf
    step(1, 32'h7FC1_2345, 32'h3F80_0000, 0, "R10");  // NaN input
    step(1, 32'h3F80_0000, 32'hFF80_0001, 0, "R10");  // signalling NaN input
    step(1, 32'h7F80_0000, 32'h7F80_0000, 1, "R10");  // inf - inf
    step(1, 32'h7F80_0000, 32'h40A0_0000, 0, "R11");  // inf + 5
    step(1, 32'h3F80_0000, 32'h7F80_0000, 1, "R11");  // 1 - inf
    step(1, 32'hFF80_0000, 32'h7F80_0000, 1, "R11");  // -inf - inf
    repeat (3) idle("R1");

    for (int i = 0; i < 400; i++) begin
      next_rand(ra);
      next_rand(rm);
      rb = (i % 2 == 0) ? (ra ^ (rm & 32'h83FF_FFFF)) : rm;
      if (i % 7 == 3) idle("R1");
      else step(1, ra, rb, rm[5], "R2");
    end
    repeat (4) idle("R1");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule